// File: doc/BRIEF.md
# Single-Bit Operate-and-Test Execution Unit

This unit carries out one single-bit operation per command on an 8-bit operand: force a bit high, force it low, flip it, or examine it without changing anything. The bit number comes from a 3-bit field of the command or from an 8-bit general register. The operand is a register value supplied with the command, a memory byte addressed by a 16-bit pointer register, or a memory byte at an 8-bit absolute address in the highest page of the address space.

A register operand completes in the cycle after the command is accepted. The unit presents the new register value with a write strobe for the register file, or, for the examine operation, a new flag byte with its own strobe. A memory operand uses a byte bus with a request/ready handshake. The unit reads the byte once, applies the change and writes the byte back once to the same address. The examine operation reads the byte and does not write it. The surrounding core keeps the flag byte and the register file. This unit only returns values and strobes for them.

Top module: `bitop_exec_unit`

## Requirements
- R1: With a register target (target code 0), operation codes 0 (set), 1 (clear) and 2 (invert) return the operand with only the selected bit forced to 1, forced to 0 or complemented on `rd_out`. `rd_we` and `done` are high in the cycle after `start`, and `ccr_we` stays low.
- R2: Operation code 3 (test) never raises `rd_we` or a bus write. In its final cycle it raises `ccr_we` and returns `ccr_out` equal to the flag byte captured at `start`, except bit 2 (the zero flag). Bit 2 is 1 when the selected bit is 0 and 0 when the selected bit is 1.
- R3: When `bit_from_reg` is 1, the bit number is the low 3 bits of `bit_reg` and the upper 5 bits and `bit_imm` have no effect. When `bit_from_reg` is 0, the bit number is `bit_imm`.
- R4: Target code 1 addresses memory at `ptr_val`. Target codes 2 and 3 address memory at `{8'hFF, abs_addr}`.
- R5: A set, clear or invert on a memory target issues exactly one read and then exactly one write to the same address. The write data is the modified byte. With a zero-wait bus, `done` is high in the 8th cycle counting the `start` cycle as the 1st.
- R6: A test on a memory target issues exactly one read and no write. With a zero-wait bus, `done` is high in the 6th cycle.
- R7: `busy` is high in every cycle from the one after `start` through the `done` cycle, and low in the cycle after `done`.
- R8: While `mem_req` is high and `mem_rdy` is low, the request, its direction and its address hold. Each such wait cycle lengthens the operation by one cycle.
- R9: Set, clear and invert on a memory target raise neither `rd_we` nor `ccr_we`.
- R10: `start` is ignored while `busy` is high. The running operation completes unchanged and no second operation follows.
- R11: After reset, `busy`, `done`, `mem_req`, `rd_we` and `ccr_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a command (only when idle) |
| op | input | 2 | 0 set, 1 clear, 2 invert, 3 test |
| tgt | input | 2 | 0 register, 1 pointer memory, 2/3 absolute memory |
| bit_from_reg | input | 1 | Bit number source: 1 register, 0 immediate |
| bit_imm | input | 3 | Immediate bit number |
| bit_reg | input | 8 | Register holding the bit number |
| rd_val | input | 8 | Register operand value |
| ptr_val | input | 16 | Pointer register for memory target |
| abs_addr | input | 8 | Absolute page offset |
| ccr_in | input | 8 | Current flag byte |
| mem_rdata | input | 8 | Bus read data |
| mem_rdy | input | 1 | Bus ready, completes the current request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final cycle of an operation |
| rd_out | output | 8 | New register value |
| rd_we | output | 1 | Register write strobe |
| ccr_out | output | 8 | New flag byte |
| ccr_we | output | 1 | Flag byte write strobe |
| mem_req | output | 1 | Bus request |
| mem_wr | output | 1 | Request is a write |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Bus write data |

## Verification
A wrong sequencer state shows up as a wrong cycle count or a second or missing bus transfer. Both are visible on `done` and the bus handshake within the 6 or 8 cycles of one operation. A wrongly latched bit number, operand or address shows up at the latest in the final cycle, as a wrong `rd_out`, `mem_wdata`, `mem_addr` or zero flag. A strobe raised for the wrong operation class corrupts a register or flag in the same cycle, so strobes are compared against the expected operation class on every command.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [1:0] {
        OP_SET = 2'd0,
        OP_CLR = 2'd1,
        OP_INV = 2'd2,
        OP_TST = 2'd3
    } bop_e;

    typedef enum logic [1:0] {
        TGT_REG  = 2'd0,
        TGT_PTR  = 2'd1,
        TGT_ABS  = 2'd2,
        TGT_ABSX = 2'd3
    } tgt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_RD,
        ST_MOD,
        ST_WR,
        ST_POST,
        ST_FIN
    } seq_st_e;

    function automatic logic tgt_is_mem(input tgt_e t);
        return t != TGT_REG;
    endfunction

    function automatic logic op_writes(input bop_e o);
        return o != OP_TST;
    endfunction

endpackage

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  bop_e              op,
    input  logic [IDX_W-1:0]  bidx,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] result,
    output logic              bit_val
);
    logic [DATA_W-1:0] sel;

    for (genvar g = 0; g < DATA_W; g++) begin : g_dec
        assign sel[g] = (bidx == IDX_W'(g));
    end

    assign bit_val = |(opnd & sel);

    always_comb begin
        unique case (op)
            OP_SET:  result = opnd | sel;
            OP_CLR:  result = opnd & ~sel;
            OP_INV:  result = opnd ^ sel;
            default: result = opnd;
        endcase
    end
endmodule

// File: rtl/bitop_addr_gen.sv
module bitop_addr_gen
    import bitop_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ABS_W  = 8,
    localparam int HI_W  = ADDR_W - ABS_W
) (
    input  tgt_e              tgt,
    input  logic [ADDR_W-1:0] ptr_val,
    input  logic [ABS_W-1:0]  abs_addr,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        unique case (tgt)
            TGT_PTR:          addr = ptr_val;
            TGT_ABS, TGT_ABSX: addr = {{HI_W{1'b1}}, abs_addr};
            default:          addr = '0;
        endcase
    end
endmodule

// File: rtl/bitop_seq.sv
module bitop_seq
    import bitop_pkg::*;
#(
    parameter int PRE_STATES = 2,
    localparam int CNT_W = (PRE_STATES > 1) ? $clog2(PRE_STATES) : 1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    start_mem,
    input  logic    start_test,
    input  logic    mem_rdy,
    output seq_st_e st,
    output logic    accept
);
    seq_st_e    nxt;
    logic       test_q;
    logic [CNT_W-1:0] cnt_q;

    assign accept = (st == ST_IDLE) && start;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: if (start) nxt = start_mem ? ST_PRE : ST_FIN;
            ST_PRE:  if (cnt_q == CNT_W'(PRE_STATES - 1)) nxt = ST_RD;
            ST_RD:   if (mem_rdy) nxt = ST_MOD;
            ST_MOD:  nxt = test_q ? ST_FIN : ST_WR;
            ST_WR:   if (mem_rdy) nxt = ST_POST;
            ST_POST: nxt = ST_FIN;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            test_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            st <= nxt;
            if (accept) test_q <= start_test;
            if (st == ST_PRE) cnt_q <= cnt_q + CNT_W'(1);
            else              cnt_q <= '0;
        end
    end
endmodule

// File: rtl/bitop_exec_unit.sv
module bitop_exec_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 16,
    parameter int ABS_W      = 8,
    parameter int CCR_W      = 8,
    parameter int ZFLAG_POS  = 2,
    parameter int PRE_STATES = 2,
    localparam int IDX_W     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [1:0]        tgt,
    input  logic              bit_from_reg,
    input  logic [IDX_W-1:0]  bit_imm,
    input  logic [DATA_W-1:0] bit_reg,
    input  logic [DATA_W-1:0] rd_val,
    input  logic [ADDR_W-1:0] ptr_val,
    input  logic [ABS_W-1:0]  abs_addr,
    input  logic [CCR_W-1:0]  ccr_in,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rdy,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_out,
    output logic              rd_we,
    output logic [CCR_W-1:0]  ccr_out,
    output logic              ccr_we,
    output logic              mem_req,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    typedef struct packed {
        bop_e              op;
        tgt_e              tgt;
        logic [IDX_W-1:0]  bidx;
        logic [ADDR_W-1:0] addr;
        logic [CCR_W-1:0]  ccr;
    } cmd_t;

    cmd_t              cmd_q;
    logic [DATA_W-1:0] opnd_q;
    bop_e              op_in;
    tgt_e              tgt_in;
    logic [ADDR_W-1:0] addr_in;
    logic [IDX_W-1:0]  bidx_in;
    seq_st_e           st;
    logic              accept;
    logic [DATA_W-1:0] result;
    logic              bit_val;

    assign op_in   = bop_e'(op);
    assign tgt_in  = tgt_e'(tgt);
    assign bidx_in = bit_from_reg ? bit_reg[IDX_W-1:0] : bit_imm;

    bitop_addr_gen #(.ADDR_W(ADDR_W), .ABS_W(ABS_W)) addr_i (
        .tgt     (tgt_in),
        .ptr_val (ptr_val),
        .abs_addr(abs_addr),
        .addr    (addr_in)
    );

    bitop_seq #(.PRE_STATES(PRE_STATES)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_mem (tgt_is_mem(tgt_in)),
        .start_test(!op_writes(op_in)),
        .mem_rdy   (mem_rdy),
        .st        (st),
        .accept    (accept)
    );

    bitop_alu #(.DATA_W(DATA_W)) alu_i (
        .op     (cmd_q.op),
        .bidx   (cmd_q.bidx),
        .opnd   (opnd_q),
        .result (result),
        .bit_val(bit_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            opnd_q <= '0;
        end else if (accept) begin
            cmd_q.op   <= op_in;
            cmd_q.tgt  <= tgt_in;
            cmd_q.bidx <= bidx_in;
            cmd_q.addr <= addr_in;
            cmd_q.ccr  <= ccr_in;
            opnd_q     <= rd_val;
        end else if (st == ST_RD && mem_rdy) begin
            opnd_q <= mem_rdata;
        end
    end

    assign busy      = (st != ST_IDLE);
    assign done      = (st == ST_FIN);
    assign mem_req   = (st == ST_RD) || (st == ST_WR);
    assign mem_wr    = (st == ST_WR);
    assign mem_addr  = cmd_q.addr;
    assign mem_wdata = result;

    assign rd_out = result;
    assign rd_we  = done && !tgt_is_mem(cmd_q.tgt) && op_writes(cmd_q.op);
    assign ccr_we = done && !op_writes(cmd_q.op);

    always_comb begin
        ccr_out            = cmd_q.ccr;
        ccr_out[ZFLAG_POS] = ~bit_val;
    end
endmodule

// File: rtl/bitop_exec_unit_chk.sv
module bitop_exec_unit_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              rd_we,
    input logic              ccr_we,
    input logic              mem_req,
    input logic              mem_wr,
    input logic              mem_rdy,
    input logic [ADDR_W-1:0] mem_addr
);
    logic [ADDR_W-1:0] rd_addr_q;

    always_ff @(posedge clk) begin
        if (rst) rd_addr_q <= '0;
        else if (mem_req && !mem_wr && mem_rdy) rd_addr_q <= mem_addr;
    end

    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_wr)));

    p_busy_until_done_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    p_idle_after_done_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    p_strobes_final_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_we || ccr_we) |-> done);

    p_strobes_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        !(rd_we && ccr_we));

    p_no_req_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    p_write_same_addr_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_wr) |-> (mem_addr == rd_addr_q));
endmodule

bind bitop_exec_unit bitop_exec_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .done    (done),
    .rd_we   (rd_we),
    .ccr_we  (ccr_we),
    .mem_req (mem_req),
    .mem_wr  (mem_wr),
    .mem_rdy (mem_rdy),
    .mem_addr(mem_addr)
);

// File: tb/bitop_exec_unit_tb_top.sv
`timescale 1ns/1ps
module bitop_exec_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic [1:0]  tgt = '0;
    logic        bit_from_reg = 1'b0;
    logic [2:0]  bit_imm = '0;
    logic [7:0]  bit_reg = '0;
    logic [7:0]  rd_val = '0;
    logic [15:0] ptr_val = '0;
    logic [7:0]  abs_addr = '0;
    logic [7:0]  ccr_in = '0;
    logic [7:0]  mem_rdata = '0;
    logic        mem_rdy;
    logic        busy, done, rd_we, ccr_we, mem_req, mem_wr;
    logic [7:0]  rd_out, ccr_out, mem_wdata;
    logic [15:0] mem_addr;

    int n_checks = 0;
    int n_fail   = 0;

    int          wait_n = 0;
    int          wcnt = 0;
    int          n_rd, n_wr;
    logic [15:0] rd_addr_seen, wr_addr_seen;
    logic [7:0]  wdata_seen;

    // captured results of the last operation
    int         cycles;
    logic       got_rd_we, got_ccr_we, busy_ok, busy_after;
    logic [7:0] got_rd, got_ccr;

    always #2 clk = ~clk;

    assign mem_rdy = mem_req && (wcnt >= wait_n);

    always @(posedge clk) begin
        if (mem_req && !mem_rdy) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (mem_req && mem_rdy) begin
            if (mem_wr) begin
                n_wr <= n_wr + 1;
                wr_addr_seen <= mem_addr;
                wdata_seen <= mem_wdata;
            end else begin
                n_rd <= n_rd + 1;
                rd_addr_seen <= mem_addr;
            end
        end
    end

    bitop_exec_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .op(op), .tgt(tgt),
        .bit_from_reg(bit_from_reg), .bit_imm(bit_imm), .bit_reg(bit_reg),
        .rd_val(rd_val), .ptr_val(ptr_val), .abs_addr(abs_addr), .ccr_in(ccr_in),
        .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .busy(busy), .done(done),
        .rd_out(rd_out), .rd_we(rd_we), .ccr_out(ccr_out), .ccr_we(ccr_we),
        .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Launch one command; poke=1 pulses start again in the 3rd cycle.
    task automatic run_op(input logic [1:0] o, input logic [1:0] t, input logic src,
                          input logic [2:0] imm, input logic [7:0] breg,
                          input logic [7:0] rv, input logic [15:0] ptr,
                          input logic [7:0] ab, input logic [7:0] cc,
                          input logic [7:0] rdata, input int w, input logic poke);
        @(negedge clk);
        n_rd = 0; n_wr = 0; wait_n = w;
        op = o; tgt = t; bit_from_reg = src; bit_imm = imm; bit_reg = breg;
        rd_val = rv; ptr_val = ptr; abs_addr = ab; ccr_in = cc; mem_rdata = rdata;
        start = 1'b1;
        cycles = 1; busy_ok = 1'b1;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            start = 1'b0;
            rd_val = 8'h5A; ptr_val = 16'hDEAD; ccr_in = 8'h33;
            cycles++;
            if (poke && cycles == 3) begin
                start = 1'b1; op = 2'd0; tgt = 2'd0;
            end
            if (!busy) busy_ok = 1'b0;
            if (done) break;
        end
        got_rd_we = rd_we; got_rd = rd_out; got_ccr_we = ccr_we; got_ccr = ccr_out;
        start = 1'b0;
        @(negedge clk);
        busy_after = busy;
    endtask

    task automatic t_reset();
        check(!busy && !done, "R11 busy/done", {busy, done}, 0);
        check(!mem_req && !rd_we && !ccr_we, "R11 strobes", {mem_req, rd_we, ccr_we}, 0);
    endtask

    task automatic reg_modify(input logic [1:0] o, input logic [2:0] b,
                              input logic [7:0] rv, input logic [7:0] exp);
        run_op(o, 2'd0, 1'b0, b, 8'h00, rv, 16'h0, 8'h0, 8'h00, 8'h00, 0, 1'b0);
        check(cycles == 2, "R1 cycles", cycles, 2);
        check(got_rd_we && !got_ccr_we, "R1 strobes", {got_rd_we, got_ccr_we}, 2);
        check(got_rd == exp, "R1 result", got_rd, exp);
        check(!busy_after, "R7 idle after done", busy_after, 0);
    endtask

    task automatic t_reg_ops();
        reg_modify(2'd0, 3'd3, 8'hA0, 8'hA8);
        reg_modify(2'd1, 3'd7, 8'hA8, 8'h28);
        reg_modify(2'd2, 3'd0, 8'h28, 8'h29);
        reg_modify(2'd2, 3'd5, 8'h29, 8'h09);
    endtask

    task automatic t_reg_test();
        run_op(2'd3, 2'd0, 1'b0, 3'd4, 8'h00, 8'h10, 16'h0, 8'h0, 8'hA4, 8'h00, 0, 1'b0);
        check(cycles == 2, "R2 cycles", cycles, 2);
        check(!got_rd_we && got_ccr_we, "R2 strobes", {got_rd_we, got_ccr_we}, 1);
        check(got_ccr == 8'hA0, "R2 Z clear on set bit", got_ccr, 8'hA0);
        run_op(2'd3, 2'd0, 1'b0, 3'd3, 8'h00, 8'h10, 16'h0, 8'h0, 8'h5B, 8'h00, 0, 1'b0);
        check(got_ccr == 8'h5F, "R2 Z set on clear bit", got_ccr, 8'h5F);
    endtask

    task automatic t_bit_from_reg();
        run_op(2'd0, 2'd0, 1'b1, 3'd7, 8'hFD, 8'h00, 16'h0, 8'h0, 8'h00, 8'h00, 0, 1'b0);
        check(got_rd == 8'h20, "R3 low bits of register", got_rd, 8'h20);
        run_op(2'd1, 2'd0, 1'b1, 3'd0, 8'h7A, 8'hFF, 16'h0, 8'h0, 8'h00, 8'h00, 0, 1'b0);
        check(got_rd == 8'hFB, "R3 upper bits ignored", got_rd, 8'hFB);
    endtask

    task automatic t_mem_ptr_modify();
        run_op(2'd2, 2'd1, 1'b0, 3'd7, 8'h00, 8'h00, 16'h1234, 8'h0, 8'h00, 8'h0F, 0, 1'b0);
        check(cycles == 8, "R5 cycles", cycles, 8);
        check(n_rd == 1 && n_wr == 1, "R5 one read one write", n_rd * 16 + n_wr, 8'h11);
        check(rd_addr_seen == 16'h1234 && wr_addr_seen == 16'h1234, "R4 pointer address",
              wr_addr_seen, 16'h1234);
        check(wdata_seen == 8'h8F, "R5 write data", wdata_seen, 8'h8F);
        check(!got_rd_we && !got_ccr_we, "R9 no strobes", {got_rd_we, got_ccr_we}, 0);
        check(busy_ok && !busy_after, "R7 busy window", {busy_ok, busy_after}, 2);
    endtask

    task automatic t_mem_abs();
        run_op(2'd3, 2'd2, 1'b0, 3'd6, 8'h00, 8'h00, 16'h0, 8'h3C, 8'h04, 8'h40, 0, 1'b0);
        check(cycles == 6, "R6 cycles", cycles, 6);
        check(n_rd == 1 && n_wr == 0, "R6 read only", n_rd * 16 + n_wr, 8'h10);
        check(rd_addr_seen == 16'hFF3C, "R4 absolute address", rd_addr_seen, 16'hFF3C);
        check(got_ccr_we && got_ccr == 8'h00, "R2 memory test flag", got_ccr, 8'h00);
        run_op(2'd0, 2'd3, 1'b0, 3'd1, 8'h00, 8'h00, 16'h0, 8'h80, 8'h00, 8'h00, 0, 1'b0);
        check(wr_addr_seen == 16'hFF80 && wdata_seen == 8'h02, "R4 code 3 absolute",
              wr_addr_seen, 16'hFF80);
        check(cycles == 8, "R5 absolute cycles", cycles, 8);
    endtask

    task automatic t_wait_states();
        run_op(2'd1, 2'd1, 1'b0, 3'd0, 8'h00, 8'h00, 16'h0042, 8'h0, 8'h00, 8'hFF, 2, 1'b0);
        check(cycles == 12, "R8 stretched cycles", cycles, 12);
        check(n_rd == 1 && n_wr == 1 && wdata_seen == 8'hFE, "R8 transfers", wdata_seen, 8'hFE);
        wait_n = 0;
    endtask

    task automatic t_start_while_busy();
        run_op(2'd3, 2'd1, 1'b0, 3'd2, 8'h00, 8'h00, 16'h0100, 8'h0, 8'h00, 8'h04, 0, 1'b1);
        check(cycles == 6 && n_wr == 0, "R10 op unchanged", cycles, 6);
        check(got_ccr == 8'h00 && !got_rd_we, "R10 result unchanged", got_ccr, 8'h00);
        check(!busy_after, "R10 no second op", busy_after, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_reg_ops();
        t_reg_test();
        t_bit_from_reg();
        t_mem_ptr_modify();
        t_mem_abs();
        t_wait_states();
        t_start_while_busy();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule